// File: doc/BRIEF.md
# Privileged Trap Entry and Return Controller

This block steers a 64-bit core into and out of its privileged handler mode. When the pipeline presents a take-trap strobe with a fault code, the block computes the handler entry point from a handler base register plus a fixed per-fault offset. It latches the address to resume at and decides whether the shadow copies of a sparse set of integer registers become active. When the pipeline presents a return strobe, the block either jumps back to the latched address or, if the core was not in privileged mode, turns the return into an unimplemented-opcode trap.

Privileged mode is carried in bit 0 of the program counter. Every handler vector is odd, so the entry PC is privileged. Bit 0 of the latched return address tells the return whether to leave the shadow bank enabled. All outputs are registered. The register file consumes `bank_sel_o`, a per-register mask of the banked registers. Fetch consumes `pc_o`/`npc_o` and `redirect_o`.

Top module: `priv_trap_unit`

## Requirements
- R1: One cycle after a taken trap, `pc_o` equals the handler base plus the offset for `fault_i`. The codes and offsets are: 1 reset 0x0001, 2 machine check 0x0401, 3 arithmetic 0x0501, 4 interrupt 0x0101, 5 data-TLB miss native 0x0201, 6 data-TLB miss other 0x0281, 7 alignment 0x0301, 8 data fault 0x0381, 9 data access violation 0x0381, 10 instruction-TLB miss 0x0181, 11 instruction-TLB fault 0x0181, 12 instruction access violation 0x0081, 13 unimplemented opcode 0x0481, 14 FP disabled 0x0581, 15 privileged call 0x2001, and 16 integer overflow 0x0501.
- R2: `npc_o` always equals `pc_o` plus 4.
- R3: On a taken trap, `ret_addr_o` is loaded from `pc_i`. The exception is an interrupt (code 4) taken while `pc_i[0]` is 1, which leaves `ret_addr_o` unchanged.
- R4: For codes 3, 15 and 16, the loaded return address is `pc_i` plus 4.
- R5: A taken trap with `pc_i[0]` equal to 0 enables the shadow bank (`shadow_o` becomes 1). A trap with `pc_i[0]` equal to 1 leaves `shadow_o` unchanged.
- R6: `bank_sel_o` has bits 8 to 14 and bit 25 set while `shadow_o` is 1, and is all zero otherwise.
- R7: A return strobe with `pc_i[0]` equal to 0 acts as a trap with code 13. Its target is base plus 0x0481, the return address is loaded with `pc_i`, and the shadow bank is enabled.
- R8: A return strobe with `pc_i[0]` equal to 1 sets `pc_o` to `ret_addr_o`. It clears `shadow_o` only when bit 0 of that address is 0. `redirect_o` pulses for every trap or return.
- R9: `intr_chk_o` pulses for one cycle after, and only after, a return taken from privileged mode.
- R10: Reset gives `pc_o` equal to the reset base plus 0x0001, `shadow_o` equal to 1, `ret_addr_o` equal to 0, and `err_o`, `intr_chk_o` and `redirect_o` equal to 0.
- R11: `err_o` pulses when a trap or return asks for the shadow state that is already current. The requested state is still held.
- R12: When the trap and return strobes arrive together, only the trap is taken.
- R13: A write on `base_we_i` sets the handler base for traps in later cycles. A trap in the same cycle as the write uses the old base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | XLEN | PC of the instruction at the trap/return point |
| fault_i | input | 5 | Fault code, as listed in R1 |
| trap_i | input | 1 | Take-trap strobe |
| ret_i | input | 1 | Return-from-handler strobe |
| base_we_i | input | 1 | Handler base write strobe |
| base_wd_i | input | XLEN | Handler base write value |
| pc_o | output | XLEN | New PC |
| npc_o | output | XLEN | New PC plus 4 |
| redirect_o | output | 1 | One-cycle pulse: `pc_o` was just loaded |
| ret_addr_o | output | XLEN | Latched return address |
| shadow_o | output | 1 | Shadow bank enabled |
| bank_sel_o | output | NREG | Per-register shadow select |
| err_o | output | 1 | Redundant shadow-state request |
| intr_chk_o | output | 1 | Request an interrupt re-check |

## Verification
Two collisions matter most. The first is a trap and a return strobe in the same cycle. The bench drives both with the return from a non-privileged PC and from a privileged one, and expects the trap vector, the trap's return-address rule and no interrupt-check pulse. The second is a shadow-entry request in the same cycle as a shadow bank that is already on, which shows up as a return from user mode while the bank is still enabled. There the bench expects the unimplemented-opcode entry and the error pulse in the same output cycle, with the bank left on. A behavioural model advanced every clock judges both cases, along with a run of pseudo-random strobes, base writes and PCs.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [4:0] {
    FC_NONE    = 5'd0,
    FC_RESET   = 5'd1,
    FC_MCHK    = 5'd2,
    FC_ARITH   = 5'd3,
    FC_INTR    = 5'd4,
    FC_DMISS_N = 5'd5,
    FC_DMISS_O = 5'd6,
    FC_ALIGN   = 5'd7,
    FC_DFAULT  = 5'd8,
    FC_DACV    = 5'd9,
    FC_IMISS   = 5'd10,
    FC_IFAULT  = 5'd11,
    FC_IACV    = 5'd12,
    FC_BADOP   = 5'd13,
    FC_FPOFF   = 5'd14,
    FC_PCALL   = 5'd15,
    FC_IOVF    = 5'd16
  } fault_e;

  localparam int OFF_W = 16;

  // Handler entry offset per fault class; all offsets carry bit 0 = 1.
  function automatic logic [OFF_W-1:0] vec_off(fault_e f);
    case (f)
      FC_RESET:            vec_off = 16'h0001;
      FC_MCHK:             vec_off = 16'h0401;
      FC_ARITH, FC_IOVF:   vec_off = 16'h0501;
      FC_INTR:             vec_off = 16'h0101;
      FC_DMISS_N:          vec_off = 16'h0201;
      FC_DMISS_O:          vec_off = 16'h0281;
      FC_ALIGN:            vec_off = 16'h0301;
      FC_DFAULT, FC_DACV:  vec_off = 16'h0381;
      FC_IMISS, FC_IFAULT: vec_off = 16'h0181;
      FC_IACV:             vec_off = 16'h0081;
      FC_BADOP:            vec_off = 16'h0481;
      FC_FPOFF:            vec_off = 16'h0581;
      FC_PCALL:            vec_off = 16'h2001;
      default:             vec_off = 16'h0000;
    endcase
  endfunction

  // Trap classes that resume after the trapping instruction.
  function automatic logic skips_insn(fault_e f);
    skips_insn = (f == FC_PCALL) || (f == FC_ARITH) || (f == FC_IOVF);
  endfunction

endpackage

// File: rtl/trap_vec.sv
module trap_vec
  import trap_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] base_i,
  input  fault_e          fault_i,
  output logic [XLEN-1:0] target_o,
  output logic            skip_o
);
  localparam int PAD = XLEN - OFF_W;

  always_comb begin
    target_o = base_i + {{PAD{1'b0}}, vec_off(fault_i)};
    skip_o   = skips_insn(fault_i);
  end
endmodule

// File: rtl/shadow_ctl.sv
module shadow_ctl (
  input  logic clk,
  input  logic rst,
  input  logic set_req_i,
  input  logic clr_req_i,
  output logic shadow_o,
  output logic err_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_o <= 1'b1;
      err_o    <= 1'b0;
    end else begin
      err_o <= (set_req_i & shadow_o) | (clr_req_i & ~shadow_o);
      if (set_req_i)      shadow_o <= 1'b1;
      else if (clr_req_i) shadow_o <= 1'b0;
    end
  end
endmodule

// File: rtl/priv_trap_unit.sv
module priv_trap_unit
  import trap_pkg::*;
#(
  parameter int              XLEN      = 64,
  parameter int              NREG      = 32,
  parameter logic [NREG-1:0] BANK_MASK = 32'h0200_7F00,
  parameter logic [XLEN-1:0] BASE_RST  = 64'h0000_0000_0001_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] pc_i,
  input  logic [4:0]      fault_i,
  input  logic            trap_i,
  input  logic            ret_i,
  input  logic            base_we_i,
  input  logic [XLEN-1:0] base_wd_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] npc_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] ret_addr_o,
  output logic            shadow_o,
  output logic [NREG-1:0] bank_sel_o,
  output logic            err_o,
  output logic            intr_chk_o
);
  localparam logic [XLEN-1:0] STEP     = XLEN'(4);
  localparam logic [XLEN-1:0] RST_PC   = BASE_RST + XLEN'(vec_off(FC_RESET));

  logic [XLEN-1:0] base_q;
  logic [XLEN-1:0] target;
  logic            skip;
  logic            in_priv;
  logic            take;
  logic            do_ret;
  logic            ra_load;
  fault_e          eff_fault;

  // Decode: trap has priority; a return from user mode becomes a bad-opcode trap.
  always_comb begin
    in_priv   = pc_i[0];
    take      = trap_i | (ret_i & ~in_priv);
    do_ret    = ret_i & ~trap_i & in_priv;
    eff_fault = trap_i ? fault_e'(fault_i) : FC_BADOP;
    ra_load   = take & ~((eff_fault == FC_INTR) & in_priv);
  end

  trap_vec #(.XLEN(XLEN)) u_vec (
    .base_i   (base_q),
    .fault_i  (eff_fault),
    .target_o (target),
    .skip_o   (skip)
  );

  shadow_ctl u_shadow (
    .clk       (clk),
    .rst       (rst),
    .set_req_i (take & ~in_priv),
    .clr_req_i (do_ret & ~ret_addr_o[0]),
    .shadow_o  (shadow_o),
    .err_o     (err_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q     <= BASE_RST;
      pc_o       <= RST_PC;
      npc_o      <= RST_PC + STEP;
      ret_addr_o <= '0;
      redirect_o <= 1'b0;
      intr_chk_o <= 1'b0;
    end else begin
      redirect_o <= take | do_ret;
      intr_chk_o <= do_ret;
      if (base_we_i) base_q <= base_wd_i;
      if (take) begin
        pc_o  <= target;
        npc_o <= target + STEP;
        if (ra_load) ret_addr_o <= skip ? pc_i + STEP : pc_i;
      end else if (do_ret) begin
        pc_o  <= ret_addr_o;
        npc_o <= ret_addr_o + STEP;
      end
    end
  end

  // Fixed banked subset, one select per architectural register.
  for (genvar g = 0; g < NREG; g++) begin : g_bank
    if (BANK_MASK[g]) begin : g_on
      assign bank_sel_o[g] = shadow_o;
    end else begin : g_off
      assign bank_sel_o[g] = 1'b0;
    end
  end

endmodule

// File: rtl/priv_trap_chk.sv
module priv_trap_chk #(
  parameter int              XLEN      = 64,
  parameter int              NREG      = 32,
  parameter logic [NREG-1:0] BANK_MASK = 32'h0200_7F00
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] pc_i,
  input logic [4:0]      fault_i,
  input logic            trap_i,
  input logic            ret_i,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] npc_o,
  input logic            redirect_o,
  input logic [XLEN-1:0] ret_addr_o,
  input logic            shadow_o,
  input logic [NREG-1:0] bank_sel_o,
  input logic            err_o,
  input logic            intr_chk_o
);
  a_r2_npc_step: assert property (@(posedge clk) disable iff (rst)
    npc_o == pc_o + XLEN'(4));

  a_r5_entry_enables: assert property (@(posedge clk) disable iff (rst)
    (trap_i && !pc_i[0]) |=> shadow_o);

  a_r5_priv_trap_keeps: assert property (@(posedge clk) disable iff (rst)
    (trap_i && pc_i[0]) |=> $stable(shadow_o));

  a_r3_intr_in_priv: assert property (@(posedge clk) disable iff (rst)
    (trap_i && fault_i == 5'd4 && pc_i[0]) |=> $stable(ret_addr_o));

  a_r6_bank_sel: assert property (@(posedge clk) disable iff (rst)
    bank_sel_o == (shadow_o ? BANK_MASK : '0));

  a_r7_user_return: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !trap_i && !pc_i[0]) |=> (redirect_o && !intr_chk_o && shadow_o));

  a_r9_check_cause: assert property (@(posedge clk) disable iff (rst)
    intr_chk_o |-> $past(ret_i && !trap_i && pc_i[0]));

  a_r11_err_cause: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(trap_i || ret_i));

  a_r12_trap_wins: assert property (@(posedge clk) disable iff (rst)
    (trap_i && ret_i) |=> (redirect_o && !intr_chk_o));
endmodule

bind priv_trap_unit priv_trap_chk #(
  .XLEN(XLEN), .NREG(NREG), .BANK_MASK(BANK_MASK)
) i_priv_trap_chk (
  .clk(clk), .rst(rst), .pc_i(pc_i), .fault_i(fault_i), .trap_i(trap_i),
  .ret_i(ret_i), .pc_o(pc_o), .npc_o(npc_o), .redirect_o(redirect_o),
  .ret_addr_o(ret_addr_o), .shadow_o(shadow_o), .bank_sel_o(bank_sel_o),
  .err_o(err_o), .intr_chk_o(intr_chk_o)
);

// File: tb/test_priv_trap_unit.sv
module test_priv_trap_unit;
  localparam int          XLEN = 64;
  localparam int          NREG = 32;
  localparam logic [31:0] MASK = 32'h0200_7F00;
  localparam logic [63:0] B0   = 64'h1_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [63:0] pc_i = '0;
  logic [4:0]  fault_i = '0;
  logic trap_i = 1'b0, ret_i = 1'b0, base_we_i = 1'b0;
  logic [63:0] base_wd_i = '0;
  logic [63:0] pc_o, npc_o, ret_addr_o;
  logic redirect_o, shadow_o, err_o, intr_chk_o;
  logic [31:0] bank_sel_o;

  always #2 clk = ~clk;

  priv_trap_unit i_priv_trap_unit (
    .clk(clk), .rst(rst), .pc_i(pc_i), .fault_i(fault_i), .trap_i(trap_i),
    .ret_i(ret_i), .base_we_i(base_we_i), .base_wd_i(base_wd_i),
    .pc_o(pc_o), .npc_o(npc_o), .redirect_o(redirect_o),
    .ret_addr_o(ret_addr_o), .shadow_o(shadow_o), .bank_sel_o(bank_sel_o),
    .err_o(err_o), .intr_chk_o(intr_chk_o)
  );

  int n_run = 0, n_fail = 0;

  function automatic logic [63:0] offs(int f);
    case (f)
      1: return 64'h0001;  2: return 64'h0401;  3: return 64'h0501;
      4: return 64'h0101;  5: return 64'h0201;  6: return 64'h0281;
      7: return 64'h0301;  8: return 64'h0381;  9: return 64'h0381;
      10: return 64'h0181; 11: return 64'h0181; 12: return 64'h0081;
      13: return 64'h0481; 14: return 64'h0581; 15: return 64'h2001;
      16: return 64'h0501; default: return 64'h0;
    endcase
  endfunction

  // Behavioural reference model, advanced every rising edge.
  logic [63:0] m_pc, m_ra, m_base;
  logic m_sh, m_err, m_ic, m_rd;
  always @(posedge clk) begin
    if (rst) begin
      m_base = B0; m_pc = B0 + 64'h1; m_ra = '0;
      m_sh = 1'b1; m_err = 1'b0; m_ic = 1'b0; m_rd = 1'b0;
    end else begin
      int f;
      m_err = 1'b0; m_ic = 1'b0; m_rd = 1'b0;
      f = trap_i ? int'(fault_i) : 13;
      if (trap_i || (ret_i && !pc_i[0])) begin
        m_rd = 1'b1;
        if (!(f == 4 && pc_i[0]))
          m_ra = pc_i + ((f == 3 || f == 15 || f == 16) ? 64'd4 : 64'd0);
        if (!pc_i[0]) begin
          if (m_sh) m_err = 1'b1;
          m_sh = 1'b1;
        end
        m_pc = m_base + offs(f);
      end else if (ret_i) begin
        m_rd = 1'b1; m_ic = 1'b1;
        m_pc = m_ra;
        if (!m_ra[0]) begin
          if (!m_sh) m_err = 1'b1;
          m_sh = 1'b0;
        end
      end
      if (base_we_i) m_base = base_wd_i;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare against the model on every falling edge.
  always @(negedge clk) if (!rst) begin
    chk("R1 pc", pc_o, m_pc);
    chk("R2 npc", npc_o, m_pc + 64'd4);
    chk("R3 ret_addr", ret_addr_o, m_ra);
    chk("R5 shadow", 64'(shadow_o), 64'(m_sh));
    chk("R6 bank_sel", 64'(bank_sel_o), m_sh ? 64'(MASK) : 64'd0);
    chk("R8 redirect", 64'(redirect_o), 64'(m_rd));
    chk("R9 intr_chk", 64'(intr_chk_o), 64'(m_ic));
    chk("R11 err", 64'(err_o), 64'(m_err));
  end

  task automatic step(logic t, logic r, int f, logic [63:0] pc);
    @(negedge clk);
    trap_i = t; ret_i = r; fault_i = 5'(f); pc_i = pc;
    @(negedge clk);
    trap_i = 1'b0; ret_i = 1'b0; base_we_i = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R10 reset pc", pc_o, B0 + 64'h1);
    chk("R10 reset shadow", 64'(shadow_o), 64'd1);
    chk("R10 reset ra", ret_addr_o, 64'd0);
    chk("R10 reset pulses", 64'({err_o, intr_chk_o, redirect_o}), 64'd0);

    step(1'b0, 1'b1, 0, B0 + 64'h1);          // priv return to 0, bank off
    chk("R8 return clears shadow", 64'(shadow_o), 64'd0);
    step(1'b1, 1'b0, 7, 64'h2000);            // alignment from user
    chk("R1 align vector", pc_o, B0 + 64'h301);
    step(1'b0, 1'b1, 0, pc_o);
    step(1'b1, 1'b0, 15, 64'h3000);           // privileged call
    chk("R4 call skips", ret_addr_o, 64'h3004);
    step(1'b1, 1'b0, 4, pc_o + 64'd4);        // interrupt inside handler
    chk("R3 interrupt keeps ra", ret_addr_o, 64'h3004);
    step(1'b1, 1'b0, 2, 64'h1_2009);          // mcheck inside handler
    step(1'b0, 1'b1, 0, pc_o);                // ra bit0=1: bank stays
    chk("R8 odd ra keeps shadow", 64'(shadow_o), 64'd1);
    step(1'b0, 1'b1, 0, 64'h4000);            // user return, bank already on
    chk("R7 user return vector", pc_o, B0 + 64'h481);
    chk("R11 redundant enable", 64'(err_o), 64'd1);
    step(1'b0, 1'b1, 0, pc_o);
    step(1'b0, 1'b1, 0, B0 + 64'h1);          // clears again: error
    chk("R11 redundant clear", 64'(err_o), 64'd1);
    step(1'b1, 1'b1, 3, 64'h5000);            // both strobes
    chk("R12 trap wins", pc_o, B0 + 64'h501);
    chk("R12 no intr check", 64'(intr_chk_o), 64'd0);
    step(1'b1, 1'b1, 9, 64'h5101);            // both strobes, priv pc
    step(1'b1, 1'b0, 16, 64'h6000);
    chk("R4 overflow skips", ret_addr_o, 64'h6004);

    @(negedge clk);
    base_we_i = 1'b1; base_wd_i = 64'h8_0000;
    trap_i = 1'b1; fault_i = 5'd14; pc_i = 64'h6101;
    @(negedge clk);
    trap_i = 1'b0; base_we_i = 1'b0;
    chk("R13 same-cycle uses old base", pc_o, B0 + 64'h581);
    step(1'b1, 1'b0, 12, 64'h7001);
    chk("R13 new base", pc_o, 64'h8_0081);

    for (int f = 1; f <= 16; f++) begin
      step(1'b1, 1'b0, f, 64'h9001);
      chk("R1 vector sweep", pc_o, 64'h8_0000 + offs(f));
    end

    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        trap_i = lf[0] & lf[3];
        ret_i  = lf[1] & ~lf[5];
        fault_i = 5'((lf[15:8] % 16) + 1);
        pc_i = {48'h0, lf[11:4], 7'h0, lf[2]};
        base_we_i = (lf[9:6] == 4'hF);
        base_wd_i = {40'h0, lf, 8'h00};
      end
      @(negedge clk);
      trap_i = 1'b0; ret_i = 1'b0; base_we_i = 1'b0;
      repeat (2) @(negedge clk);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule